// File: doc/BRIEF.md
# Integer Execute Unit with Per-Operation Immediate Extension

This block is the arithmetic and logic stage of a simple 32-bit integer pipeline. It is purely combinational: an operation code, two register operands, a 16-bit immediate, a 5-bit shift-amount field and an immediate-mode flag go in, and one 32-bit result comes out in the same cycle. The surrounding pipeline registers the result.

The unit covers wrapping add and subtract, the four bitwise logic functions, placing a constant in the upper half-word, the three shift kinds by either a fixed field or a register value, and signed and unsigned set-on-less-than. When the immediate-mode flag is set on an operation that has an immediate form, the second operand is taken from the immediate. Whether that immediate is sign- or zero-extended depends on the operation. Operations that have no immediate form ignore the flag.

Top module: `int_exec_alu`

## Requirements
- R1: Operation codes on `op_sel` are ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, UPPER=6, SLL=7, SRL=8, SRA=9, SLLV=10, SRLV=11, SRAV=12, SLT=13, SLTU=14. ADD and SUB produce the sum or difference modulo 2^32 and give no overflow indication.
- R2: ADD with `imm_mode`=1 adds the immediate after sign-extending it from bit 15.
- R3: AND, OR and XOR with `imm_mode`=1 use the immediate zero-extended, so bits 31..16 of the second operand are 0.
- R4: AND, OR and XOR with `imm_mode`=0 combine the two registers bitwise. NOR always returns the complement of the OR of the two registers.
- R5: UPPER returns the immediate in bits 31..16 and zeros in bits 15..0, whatever the register operands hold.
- R6: SLL, SRL and SRA shift `rs_val` by `shamt_val`. SLL and SRL fill with zeros. SRA fills with copies of bit 31. A shift by 0 returns the operand unchanged.
- R7: SLLV, SRLV and SRAV take the shift amount from bits 4..0 of `rt_val`. Bits 31..5 of `rt_val` have no effect.
- R8: SLT returns 1 when `rs_val` is less than the second operand as two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are always 0.
- R9: SLTU compares as unsigned numbers. In immediate mode it sign-extends the immediate first and then compares unsigned.
- R10: `imm_mode` has no effect on SUB, NOR, UPPER or any shift.
- R11: Operation code 15 produces a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see R1) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand; also the variable shift amount source |
| imm_val | input | 16 | Instruction immediate |
| shamt_val | input | 5 | Instruction shift-amount field |
| imm_mode | input | 1 | Selects the immediate as the second operand where a form exists |
| result | output | 32 | Operation result |

## Verification
The bench drives immediates with bit 15 set into every immediate-capable operation. A design that picks the wrong extension then corrupts the upper half-word, for example turning an AND-immediate mask into a sign-filled one, or making unsigned set-less-than with 0xFFFF compare against 65535 instead of 0xFFFFFFFF. Shifts by 0 and by 31 on operands with bit 31 set expose a wrong fill value or a missing stage. Variable shifts are driven with junk above bit 4 of the amount register, which catches a design that uses the whole register. Signed compares across the sign boundary catch a design that compares signed values as unsigned, and SUB in immediate mode catches a flag that leaks into operations that must ignore it.

// File: rtl/iea_pkg.sv
package iea_pkg;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_NOR   = 4'd5,
    OP_UPPER = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_SRA   = 4'd9,
    OP_SLLV  = 4'd10,
    OP_SRLV  = 4'd11,
    OP_SRAV  = 4'd12,
    OP_SLT   = 4'd13,
    OP_SLTU  = 4'd14
  } iea_op_e;

  // operations that accept the immediate as second operand
  function automatic logic has_imm_form(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_AND) || (op == OP_OR) ||
           (op == OP_XOR) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // logic operations extend their immediate with zeros
  function automatic logic wants_zero_fill(input logic [OPW-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_var_shift(input logic [OPW-1:0] op);
    return (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  endfunction
endpackage

// File: rtl/iea_imm_ext.sv
module iea_imm_ext #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 16
) (
  input  logic [IW-1:0] imm,
  input  logic          zero_fill,
  output logic [DW-1:0] ext
);
  localparam int unsigned PADW = DW - IW;

  function automatic logic [DW-1:0] widen(input logic [IW-1:0] v, input logic zf);
    logic pad_bit;
    pad_bit = zf ? 1'b0 : v[IW-1];
    return {{PADW{pad_bit}}, v};
  endfunction

  assign ext = widen(imm, zero_fill);
endmodule

// File: rtl/iea_shifter.sv
module iea_shifter #(
  parameter int unsigned DW  = 32,
  parameter int unsigned SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  din,
  input  logic [SHW-1:0] amt,
  input  logic           to_left,
  input  logic           arith,
  output logic [DW-1:0]  dout
);
  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < int'(DW); i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  logic [DW-1:0] stage [SHW+1];
  logic          fill;

  // a left shift is a right shift of the bit-reversed operand
  assign stage[0] = to_left ? flip(din) : din;
  assign fill     = arith & ~to_left & din[DW-1];

  for (genvar k = 0; k < int'(SHW); k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][DW-1:STEP]} : stage[k];
  end

  assign dout = to_left ? flip(stage[SHW]) : stage[SHW];
endmodule

// File: rtl/iea_addsub_cmp.sv
module iea_addsub_cmp #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] diff,
  output logic          lt_signed,
  output logic          lt_unsigned
);
  logic [DW:0] wide_diff;

  function automatic logic signed_less(input logic a_msb, input logic b_msb,
                                       input logic d_msb);
    // differing signs: the negative one is smaller; else the difference sign
    return (a_msb ^ b_msb) ? a_msb : d_msb;
  endfunction

  assign sum         = a + b;
  assign wide_diff   = {1'b0, a} - {1'b0, b};
  assign diff        = wide_diff[DW-1:0];
  assign lt_unsigned = wide_diff[DW];
  assign lt_signed   = signed_less(a[DW-1], b[DW-1], wide_diff[DW-1]);
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import iea_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned IW  = 16,
  parameter int unsigned SHW = $clog2(DW)
) (
  input  logic [OPW-1:0] op_sel,
  input  logic [DW-1:0]  rs_val,
  input  logic [DW-1:0]  rt_val,
  input  logic [IW-1:0]  imm_val,
  input  logic [SHW-1:0] shamt_val,
  input  logic           imm_mode,
  output logic [DW-1:0]  result
);
  localparam int unsigned LOWW = DW - IW;

  logic [DW-1:0]  imm_ext_w;
  logic [DW-1:0]  opb_w;
  logic           use_imm_w;
  logic [SHW-1:0] shift_amt_w;
  logic           shift_left_w;
  logic           shift_arith_w;
  logic [DW-1:0]  shift_out_w;
  logic [DW-1:0]  sum_w;
  logic [DW-1:0]  diff_w;
  logic           lt_s_w;
  logic           lt_u_w;

  iea_imm_ext #(.DW(DW), .IW(IW)) u_ext (
    .imm       (imm_val),
    .zero_fill (wants_zero_fill(op_sel)),
    .ext       (imm_ext_w)
  );

  assign use_imm_w = imm_mode & has_imm_form(op_sel);
  assign opb_w     = use_imm_w ? imm_ext_w : rt_val;

  iea_addsub_cmp #(.DW(DW)) u_arith (
    .a           (rs_val),
    .b           (opb_w),
    .sum         (sum_w),
    .diff        (diff_w),
    .lt_signed   (lt_s_w),
    .lt_unsigned (lt_u_w)
  );

  assign shift_amt_w   = is_var_shift(op_sel) ? rt_val[SHW-1:0] : shamt_val;
  assign shift_left_w  = (op_sel == OP_SLL) || (op_sel == OP_SLLV);
  assign shift_arith_w = (op_sel == OP_SRA) || (op_sel == OP_SRAV);

  iea_shifter #(.DW(DW), .SHW(SHW)) u_shift (
    .din     (rs_val),
    .amt     (shift_amt_w),
    .to_left (shift_left_w),
    .arith   (shift_arith_w),
    .dout    (shift_out_w)
  );

  always_comb begin
    result = '0;
    case (op_sel)
      OP_ADD:   result = sum_w;
      OP_SUB:   result = diff_w;
      OP_AND:   result = rs_val & opb_w;
      OP_OR:    result = rs_val | opb_w;
      OP_XOR:   result = rs_val ^ opb_w;
      OP_NOR:   result = ~(rs_val | rt_val);
      OP_UPPER: result = {imm_val, {LOWW{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV: result = shift_out_w;
      OP_SLT:   result = {{(DW-1){1'b0}}, lt_s_w};
      OP_SLTU:  result = {{(DW-1){1'b0}}, lt_u_w};
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/iea_checker.sv
module iea_checker
  import iea_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned IW  = 16,
  parameter int unsigned SHW = $clog2(DW)
) (
  input logic [OPW-1:0] op_sel,
  input logic [DW-1:0]  rs_val,
  input logic [DW-1:0]  rt_val,
  input logic [IW-1:0]  imm_val,
  input logic [SHW-1:0] shamt_val,
  input logic           imm_mode,
  input logic [DW-1:0]  imm_ext_w,
  input logic [SHW-1:0] shift_amt_w,
  input logic [DW-1:0]  result
);
  always_comb begin
    // R11: spare code gives zero
    a_r11_spare_zero: assert (op_sel != 4'd15 || result == '0);
    // R5: constant lands in the upper half, lower half cleared
    a_r5_upper_place: assert (op_sel != OP_UPPER ||
                              (result[IW-1:0] == '0 && result[DW-1:DW-IW] == imm_val));
    // R8 / R9: compare results are a single bit
    a_r8_compare_bool: assert (!(op_sel == OP_SLT || op_sel == OP_SLTU) ||
                               result[DW-1:1] == '0);
    // R6: logical right shift by a nonzero amount clears the top bit
    a_r6_srl_zero_top: assert (!(op_sel == OP_SRL && shamt_val != '0) ||
                               !result[DW-1]);
    // R6: arithmetic right shift keeps the sign
    a_r6_sra_keep_sign: assert (op_sel != OP_SRA || result[DW-1] == rs_val[DW-1]);
    // R1: subtraction inverts addition modulo 2^DW
    a_r1_sub_inverse: assert (op_sel != OP_SUB || (result + rt_val) == rs_val);
    // R3: zero-extended immediate masks the upper half of AND
    a_r3_and_imm_upper: assert (!(op_sel == OP_AND && imm_mode) ||
                                result[DW-1:IW] == '0);
    // R2: add-immediate sees a sign-extended immediate
    a_r2_add_sext: assert (!(op_sel == OP_ADD) ||
                           imm_ext_w[DW-1:IW] == {(DW-IW){imm_val[IW-1]}});
    // R7: variable shifts take the low bits of the register
    a_r7_var_amount: assert (!(op_sel == OP_SLLV || op_sel == OP_SRLV ||
                               op_sel == OP_SRAV) || shift_amt_w == rt_val[SHW-1:0]);
  end
endmodule

bind int_exec_alu iea_checker #(.DW(DW), .IW(IW), .SHW(SHW)) u_iea_chk (
  .op_sel      (op_sel),
  .rs_val      (rs_val),
  .rt_val      (rt_val),
  .imm_val     (imm_val),
  .shamt_val   (shamt_val),
  .imm_mode    (imm_mode),
  .imm_ext_w   (imm_ext_w),
  .shift_amt_w (shift_amt_w),
  .result      (result)
);

// File: tb/int_exec_alu_tb_top.sv
module int_exec_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N_RANDOM   = 3000;
  localparam int unsigned SEED = 32'h5EED_1234;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm_val = '0;
  logic [4:0]  shamt_val = '0;
  logic        imm_mode = 1'b0;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_alu dut_i (
    .op_sel    (op_sel),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .imm_val   (imm_val),
    .shamt_val (shamt_val),
    .imm_mode  (imm_mode),
    .result    (result)
  );

  // reference model written from the requirements
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] imm,
                                        input logic [4:0] sh, input logic im);
    logic [31:0] b_s, b_z;
    b_s = im ? 32'($signed(imm)) : b;
    b_z = im ? {16'h0000, imm} : b;
    case (op)
      4'd0:  return a + b_s;
      4'd1:  return a - b;
      4'd2:  return a & b_z;
      4'd3:  return a | b_z;
      4'd4:  return a ^ b_z;
      4'd5:  return ~a & ~b;
      4'd6:  return {imm, 16'h0000};
      4'd7:  return a << sh;
      4'd8:  return a >> sh;
      4'd9:  return 32'($signed(a) >>> sh);
      4'd10: return a << b[4:0];
      4'd11: return a >> b[4:0];
      4'd12: return 32'($signed(a) >>> b[4:0]);
      4'd13: return ($signed(a) < $signed(b_s)) ? 32'd1 : 32'd0;
      4'd14: return (a < b_s) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic im);
    case (op)
      4'd0:  return im ? "R2" : "R1";
      4'd1:  return im ? "R10" : "R1";
      4'd2, 4'd3, 4'd4: return im ? "R3" : "R4";
      4'd5:  return "R4";
      4'd6:  return "R5";
      4'd7, 4'd8, 4'd9: return "R6";
      4'd10, 4'd11, 4'd12: return "R7";
      4'd13: return "R8";
      4'd14: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] imm, input logic [4:0] sh, input logic im,
                     input string tag);
    logic [31:0] exp;
    @(negedge clk);
    op_sel = op; rs_val = a; rt_val = b; imm_val = imm; shamt_val = sh; imm_mode = im;
    exp = model(op, a, b, imm, sh, im);
    @(posedge clk);
    #(CLK_PERIOD/4);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d rs=%h rt=%h imm=%h sh=%0d im=%0b actual=%h expected=%h",
               tag, op, a, b, imm, sh, im, result, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, all requirements: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(SEED);
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs select ADD and give zero (R1)
    @(posedge clk); #(CLK_PERIOD/4);
    n_checks++;
    if (result !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 reset state actual=%h expected=%h", result, 32'h0);
    end

    run(4'd0,  32'hFFFF_FFFF, 32'h1,          16'h0,    5'd0,  1'b0, "R1 add wrap");
    run(4'd1,  32'h0,         32'h1,          16'h0,    5'd0,  1'b0, "R1 sub wrap");
    run(4'd0,  32'h0,         32'h1234_5678,  16'h8000, 5'd0,  1'b1, "R2 addi sign");
    run(4'd0,  32'h10,        32'h0,          16'hFFFF, 5'd0,  1'b1, "R2 addi minus one");
    run(4'd2,  32'hFFFF_FFFF, 32'hFFFF_FFFF,  16'h8000, 5'd0,  1'b1, "R3 andi zero ext");
    run(4'd3,  32'h0,         32'hFFFF_0000,  16'hFFFF, 5'd0,  1'b1, "R3 ori zero ext");
    run(4'd4,  32'hF0F0_F0F0, 32'h0,          16'hFFFF, 5'd0,  1'b1, "R3 xori zero ext");
    run(4'd5,  32'h0,         32'h0,          16'hFFFF, 5'd0,  1'b1, "R4 nor zeros");
    run(4'd5,  32'hA5A5_0000, 32'h0000_5A5A,  16'h0,    5'd0,  1'b0, "R4 nor mix");
    run(4'd6,  32'hDEAD_BEEF, 32'h1234_5678,  16'hABCD, 5'd0,  1'b0, "R5 upper");
    run(4'd8,  32'h8000_0000, 32'h0,          16'h0,    5'd31, 1'b0, "R6 srl 31");
    run(4'd9,  32'h8000_0000, 32'h0,          16'h0,    5'd31, 1'b0, "R6 sra 31");
    run(4'd7,  32'h0000_0001, 32'h0,          16'h0,    5'd31, 1'b0, "R6 sll 31");
    run(4'd9,  32'h8765_4321, 32'h0,          16'h0,    5'd0,  1'b0, "R6 sra 0");
    run(4'd12, 32'h8000_0000, 32'hFFFF_FFE4,  16'h0,    5'd0,  1'b0, "R7 srav junk upper");
    run(4'd10, 32'h0000_0003, 32'h0000_0021,  16'h0,    5'd9,  1'b0, "R7 sllv by 1");
    run(4'd11, 32'hFFFF_FFFF, 32'h7FFF_FFFF,  16'h0,    5'd0,  1'b0, "R7 srlv 31");
    run(4'd13, 32'h8000_0000, 32'h0,          16'h0,    5'd0,  1'b0, "R8 slt neg");
    run(4'd13, 32'h7FFF_FFFF, 32'h8000_0000,  16'h0,    5'd0,  1'b0, "R8 slt max vs min");
    run(4'd14, 32'h8000_0000, 32'h0,          16'h0,    5'd0,  1'b0, "R9 sltu");
    run(4'd14, 32'h5,         32'h0,          16'hFFFF, 5'd0,  1'b1, "R9 sltiu sext");
    run(4'd14, 32'h0001_0000, 32'h0,          16'h7FFF, 5'd0,  1'b1, "R9 sltiu pos");
    run(4'd1,  32'd10,        32'd3,          16'h1,    5'd0,  1'b1, "R10 sub imm ignored");
    run(4'd8,  32'hF000_0000, 32'h0,          16'hFFFF, 5'd4,  1'b1, "R10 srl imm ignored");
    run(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF,  16'hFFFF, 5'd31, 1'b1, "R11 spare code");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [15:0] imm;
      logic [4:0]  sh;
      logic        im;
      op  = 4'($urandom_range(0, 15));
      a   = $urandom();
      b   = $urandom();
      if ($urandom_range(0, 7) == 0) a = {1'b1, 31'($urandom_range(0, 3))};
      if ($urandom_range(0, 7) == 0) b = a;
      imm = 16'($urandom());
      sh  = 5'($urandom());
      im  = 1'($urandom());
      run(op, a, b, imm, sh, im, tag_of(op, im));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule